// File: doc/BRIEF.md
# DRAM Command Energy Accumulator

This block sits beside a memory controller's command scheduler. It watches the DRAM commands the scheduler issues and keeps a running weighted sum that estimates how much energy the memory has used. Three classes of command carry a cost: an activate, a column read and a column write. Each class has its own programmable 8-bit weight.

The activate weight covers the activate and also the precharge that later closes the same page. For this reason, precharge commands add nothing to the sum. Refresh commands also add nothing, because they run at a fixed rate and their cost is constant. Software programs the three weights through a single 32-bit configuration word, and it may rewrite them at any time.

A sample request ends the current measurement interval. On that request the block copies the running total into a snapshot register and restarts the accumulator from zero. A power or thermal manager can then read one energy figure per interval.

Top module: `dram_energy_meter`

## Requirements
- R1: The configuration word holds the activate weight in bits 7:0, the read weight in bits 15:8 and the write weight in bits 23:16. Bits 31:24 always read as zero. All three weights reset to zero. A write with `cfg_wr_en` high updates all three weights on that clock edge, and `cfg_rdata` shows the new value after that edge.
- R2: `cmd_type` encodings are 1 = activate, 3 = read and 4 = write, and these add the activate, read and write weight respectively. Encodings 0 (no-op), 2 (precharge), 5 (refresh), 6 and 7 add zero.
- R3: A command is accepted on a rising edge where `cmd_valid` is high. Its weight first appears in `energy_acc` after the next rising edge.
- R4: A cycle with `cmd_valid` low adds nothing, whatever the value of `cmd_type`.
- R5: `energy_acc` saturates at 2^ACC_W-1 and never wraps.
- R6: On an edge where `sample_req` is high, `energy_snap` takes the saturated sum of the accumulator and any weight still pending from the previous cycle's command, and `energy_acc` becomes zero. At other times `energy_snap` holds its value.
- R7: A command accepted on the same edge as `sample_req` is counted into the new interval.
- R8: A weight write on the same edge as a command does not affect that command; the command uses the old weight.
- R9: Reset clears `energy_acc`, `energy_snap` and the weights to zero.
- R10: `cmd_rank` has no effect on the energy total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 3 | Command class encoding |
| cmd_rank | input | RANK_W | Rank the command targets |
| cfg_wr_en | input | 1 | Write strobe for the weight word |
| cfg_wdata | input | 32 | Weight word write data |
| cfg_rdata | output | 32 | Weight word read data |
| sample_req | input | 1 | Close the interval: snapshot and clear |
| energy_acc | output | ACC_W | Running energy total |
| energy_snap | output | ACC_W | Energy total of the last closed interval |

## Verification
The bench builds the block with ACC_W = 12 and RANK_W = 2. With a 12-bit accumulator, twenty activates at weight 255 push the total past 4095. This makes the saturation ceiling reachable in a few cycles, where the default 32-bit width would need millions of commands. The 2-bit rank field is large enough to show that commands to different ranks add identical weights.

// File: rtl/dem_pkg.sv
// Package: shared constants and command encoding for the energy accumulator.
// Assumes one command per clock and three weighted command classes.
package dem_pkg;
    localparam int WEIGHT_W    = 8;
    localparam int NUM_WEIGHTS = 3;
    localparam int REG_W       = 32;
    localparam int CMD_W       = 3;

    // Command classes seen from the scheduler; values 6 and 7 are unused.
    typedef enum logic [CMD_W-1:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4,
        CMD_REF = 3'd5
    } dram_cmd_e;

    // Index of each weight field in the configuration word.
    localparam int IDX_ACT = 0;
    localparam int IDX_RD  = 1;
    localparam int IDX_WR  = 2;
endpackage

// File: rtl/dem_weight_regs.sv
// Module: holds the three command weights in one configuration word.
// Assumes REG_W >= NUM_WEIGHTS*WEIGHT_W; unused upper bits read as zero.
module dem_weight_regs
    import dem_pkg::*;
#(
    parameter int W_W = WEIGHT_W,
    parameter int R_W = REG_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [R_W-1:0]       wdata,
    output logic [W_W-1:0]       w_act,
    output logic [W_W-1:0]       w_rd,
    output logic [W_W-1:0]       w_wr,
    output logic [R_W-1:0]       rdata
);
    localparam int USED_W = NUM_WEIGHTS * W_W;

    logic [W_W-1:0]    field_q [NUM_WEIGHTS];
    logic [USED_W-1:0] packed_w;
    logic              unused_hi;

    for (genvar k = 0; k < NUM_WEIGHTS; k++) begin : g_field
        // Per-field storage: reset to zero, load its slice on a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                field_q[k] <= '0;
            else if (wr_en)
                field_q[k] <= wdata[k*W_W +: W_W];
        end
        assign packed_w[k*W_W +: W_W] = field_q[k];
    end

    assign unused_hi = ^wdata[R_W-1:USED_W];
    assign w_act = field_q[IDX_ACT];
    assign w_rd  = field_q[IDX_RD];
    assign w_wr  = field_q[IDX_WR];
    assign rdata = {{(R_W-USED_W){1'b0}}, packed_w};
endmodule

// File: rtl/dem_cmd_weight.sv
// Module: maps an accepted command to its weight and registers it.
// Assumes at most one command per clock; uncounted classes cost zero.
module dem_cmd_weight
    import dem_pkg::*;
#(
    parameter int W_W = WEIGHT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_type,
    input  logic [W_W-1:0]   w_act,
    input  logic [W_W-1:0]   w_rd,
    input  logic [W_W-1:0]   w_wr,
    output logic [W_W-1:0]   add_q
);
    logic [W_W-1:0] add_d;

    // Weight lookup: precharge, refresh and idle codes contribute nothing.
    always_comb begin
        add_d = '0;
        if (cmd_valid) begin
            case (cmd_type)
                CMD_ACT: add_d = w_act;
                CMD_RD:  add_d = w_rd;
                CMD_WR:  add_d = w_wr;
                default: add_d = '0;
            endcase
        end
    end

    // Pipeline register: the weight is applied one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            add_q <= '0;
        else
            add_q <= add_d;
    end
endmodule

// File: rtl/dem_accum.sv
// Module: saturating energy accumulator with snapshot-and-clear.
// Assumes the pending addend belongs to the interval that a sample closes.
module dem_accum
    import dem_pkg::*;
#(
    parameter int W_W   = WEIGHT_W,
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W_W-1:0]   add,
    input  logic             sample,
    output logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] snap_q
);
    localparam logic [ACC_W-1:0] ACC_MAX = {ACC_W{1'b1}};

    logic [ACC_W:0]   sum_wide;
    logic [ACC_W-1:0] sum_sat;

    // Saturating add: clamp at the ceiling instead of wrapping.
    always_comb begin
        sum_wide = {1'b0, acc_q} + {{(ACC_W+1-W_W){1'b0}}, add};
        sum_sat  = sum_wide[ACC_W] ? ACC_MAX : sum_wide[ACC_W-1:0];
    end

    // Total and snapshot: a sample captures the sum and restarts from zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            snap_q <= '0;
        end else if (sample) begin
            snap_q <= sum_sat;
            acc_q  <= '0;
        end else begin
            acc_q  <= sum_sat;
        end
    end
endmodule

// File: rtl/dram_energy_meter.sv
// Module: top of the DRAM command energy accumulator.
// Assumes one scheduler command per clock; the rank tag does not change cost.
module dram_energy_meter
    import dem_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int RANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_type,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic              cfg_wr_en,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              sample_req,
    output logic [ACC_W-1:0]  energy_acc,
    output logic [ACC_W-1:0]  energy_snap
);
    logic [WEIGHT_W-1:0] w_act, w_rd, w_wr, add_q;
    logic                unused_rank;

    assign unused_rank = ^cmd_rank;

    dem_weight_regs #(.W_W(WEIGHT_W), .R_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wdata(cfg_wdata),
        .w_act(w_act), .w_rd(w_rd), .w_wr(w_wr), .rdata(cfg_rdata)
    );

    dem_cmd_weight #(.W_W(WEIGHT_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .w_act(w_act), .w_rd(w_rd), .w_wr(w_wr), .add_q(add_q)
    );

    dem_accum #(.W_W(WEIGHT_W), .ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .add(add_q), .sample(sample_req),
        .acc_q(energy_acc), .snap_q(energy_snap)
    );
endmodule

// File: rtl/dram_energy_meter_chk.sv
// Checker: temporal properties of the energy accumulator ports.
module dram_energy_meter_chk #(
    parameter int ACC_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [2:0]       cmd_type,
    input logic             sample_req,
    input logic [31:0]      cfg_rdata,
    input logic [ACC_W-1:0] energy_acc,
    input logic [ACC_W-1:0] energy_snap
);
    logic [1:0] seen;
    logic       started = 1'b0;

    // Counts edges since reset so $past only looks at valid history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            seen <= '0;
        else if (seen != 2'd3)
            seen <= seen + 2'd1;
    end

    // Marks that at least one edge has happened.
    always_ff @(posedge clk) started <= 1'b1;

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:24] == 8'h00);

    assert_no_cost_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && $past(cmd_valid, 2)
         && ($past(cmd_type, 2) == 3'd2 || $past(cmd_type, 2) == 3'd5)
         && !$past(sample_req)) |-> energy_acc == $past(energy_acc));

    assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && !$past(cmd_valid, 2) && !$past(sample_req))
        |-> energy_acc == $past(energy_acc));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && !$past(sample_req)) |-> energy_acc >= $past(energy_acc));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && $past(sample_req)) |-> energy_acc == '0);

    assert_snap_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd1 && !$past(sample_req)) |-> $stable(energy_snap));

    assert_reset_R9: assert property (@(posedge clk)
        (started && $past(!rst_n)) |-> (energy_acc == '0 && energy_snap == '0));
endmodule

bind dram_energy_meter dram_energy_meter_chk #(.ACC_W(ACC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .sample_req(sample_req), .cfg_rdata(cfg_rdata),
    .energy_acc(energy_acc), .energy_snap(energy_snap)
);

// File: tb/sim_dram_energy_meter.sv
`timescale 1ns/1ps
module sim_dram_energy_meter;
    localparam int ACC_W  = 12;
    localparam int RANK_W = 2;
    localparam longint ACC_MAX = (64'd1 << ACC_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cmd_valid;
    logic [2:0]        cmd_type;
    logic [RANK_W-1:0] cmd_rank;
    logic              cfg_wr_en;
    logic [31:0]       cfg_wdata;
    logic [31:0]       cfg_rdata;
    logic              sample_req;
    logic [ACC_W-1:0]  energy_acc;
    logic [ACC_W-1:0]  energy_snap;

    always #2 clk = ~clk;

    dram_energy_meter #(.ACC_W(ACC_W), .RANK_W(RANK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_rank(cmd_rank), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .sample_req(sample_req),
        .energy_acc(energy_acc), .energy_snap(energy_snap)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    longint m_acc, m_snap, m_pend;
    longint m_w [3];

    task automatic chk(string tag, longint act, longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic longint weight_of(logic [2:0] c);
        case (c)
            3'd1:    return m_w[0];
            3'd3:    return m_w[1];
            3'd4:    return m_w[2];
            default: return 0;
        endcase
    endfunction

    // One clock: drive at negedge, update the model at the edge, compare after.
    task automatic step(bit v, logic [2:0] c, logic [1:0] r, bit s, bit w, logic [31:0] d);
        longint np;
        longint sum;
        cmd_valid = v; cmd_type = c; cmd_rank = r;
        sample_req = s; cfg_wr_en = w; cfg_wdata = d;
        @(posedge clk);
        np  = v ? weight_of(c) : 0;
        sum = m_acc + m_pend;
        if (sum > ACC_MAX) sum = ACC_MAX;
        if (s) begin m_snap = sum; m_acc = 0; end
        else m_acc = sum;
        m_pend = np;
        if (w) for (int k = 0; k < 3; k++) m_w[k] = (d >> (8*k)) & 255;
        @(negedge clk);
        chk("R3/R5 energy_acc model", energy_acc, m_acc);
        chk("R6 energy_snap model", energy_snap, m_snap);
        chk("R1 cfg_rdata model", cfg_rdata, {8'h00, m_w[2][7:0], m_w[1][7:0], m_w[0][7:0]});
    endtask

    task automatic idle();
        step(0, 3'd0, 2'd0, 0, 0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cmd_valid = 0; cmd_type = 0; cmd_rank = 0;
        cfg_wr_en = 0; cfg_wdata = 0; sample_req = 0;
        m_acc = 0; m_snap = 0; m_pend = 0;
        for (int k = 0; k < 3; k++) m_w[k] = 0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 reset energy_acc", energy_acc, 0);
        chk("R9 reset energy_snap", energy_snap, 0);
        chk("R1 reset weights", cfg_rdata, 0);
        rst_n = 1'b1;

        // R1: write with junk in reserved bits, read back packed fields
        step(0, 3'd0, 2'd0, 0, 1, 32'hAB302010);
        chk("R1 readback", cfg_rdata, 32'h00302010);

        // R3: activate weight appears one edge after acceptance
        step(1, 3'd1, 2'd0, 0, 0, 0);
        chk("R3 not yet added", energy_acc, 0);
        idle();
        chk("R3 activate added", energy_acc, 32'h10);

        // R2: precharge, refresh and unused codes cost nothing
        step(1, 3'd2, 2'd1, 0, 0, 0);
        step(1, 3'd5, 2'd2, 0, 0, 0);
        step(1, 3'd6, 2'd0, 0, 0, 0);
        step(1, 3'd0, 2'd0, 0, 0, 0);
        idle(); idle();
        chk("R2 zero-cost classes", energy_acc, 32'h10);

        // R4: invalid cycles carrying command codes add nothing
        step(0, 3'd1, 2'd0, 0, 0, 0);
        step(0, 3'd4, 2'd0, 0, 0, 0);
        idle();
        chk("R4 invalid ignored", energy_acc, 32'h10);

        // R2: read then write back to back
        step(1, 3'd3, 2'd0, 0, 0, 0);
        step(1, 3'd4, 2'd0, 0, 0, 0);
        idle();
        chk("R2 read+write", energy_acc, 32'h60);

        // R10: rank 3 read costs the same
        step(1, 3'd3, 2'd3, 0, 0, 0);
        idle();
        chk("R10 rank independent", energy_acc, 32'h80);

        // R8: weight write alongside a read uses the old read weight
        step(1, 3'd3, 2'd0, 0, 1, 32'h00300510);
        step(1, 3'd3, 2'd0, 0, 0, 0);
        chk("R8 old weight used", energy_acc, 32'hA0);

        // R6/R7: sample with a write command in the same cycle
        step(1, 3'd4, 2'd0, 1, 0, 0);
        chk("R6 snapshot", energy_snap, 32'hA5);
        chk("R6 cleared", energy_acc, 0);
        idle();
        chk("R7 new interval", energy_acc, 32'h30);

        // R5: saturation with activate weight 255
        step(0, 3'd0, 2'd0, 0, 1, 32'h003005FF);
        for (int i = 0; i < 20; i++) step(1, 3'd1, 2'd0, 0, 0, 0);
        idle(); idle();
        chk("R5 saturated", energy_acc, ACC_MAX);
        step(0, 3'd0, 2'd0, 1, 0, 0);
        chk("R5 saturated snapshot", energy_snap, ACC_MAX);
        chk("R6 cleared after saturation", energy_acc, 0);

        // Mixed traffic against the model (R2 R3 R5 R6 R7 R8)
        for (int i = 0; i < 400; i++) begin
            bit w;
            bit s;
            w = ($urandom % 10) == 0;
            s = ($urandom % 20) == 0;
            step($urandom % 4 != 0, 3'($urandom % 8), 2'($urandom % 4), s, w, $urandom);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule